// File: doc/BRIEF.md
# Two-Wire Tuner Control Slave

This block is the serial control front end of a tuning frequency synthesiser. It listens on a two-wire serial bus (I2C) and responds as a slave to one of two 7-bit device addresses. The upper five address bits are fixed at 11000. The lower two bits form a variable pair: the pair 01 is always answered, and any other pair is answered only when it equals the 2-bit select code on `addr_sel_i`. The lowest bit of the address byte selects write (0) or read (1).

In a write transfer, each data byte is routed by its first bit. A leading 0 opens a divider pair, whose two bytes fill a 15-bit divide ratio. A leading 1 opens a control pair: a control byte followed by an output-port byte. Pairs may repeat without the address being sent again. In a read transfer, the slave returns a status byte for as long as the master acknowledges. The status byte carries the power-on flag, the lock input, three digital port inputs and a 3-bit converter code.

Both bus lines pass through a two-flop synchroniser and a glitch filter before any decoding takes place. A power-on flag is set by reset or by `pwr_low_i`. While the flag is set, every programmed register stays cleared and every port output stays off.

Top module: `tuner_i2c_slave`

## Requirements
- R1: An address byte 1,1,0,0,0,MA1,MA0,RW (MSB first) is acknowledged when MA1MA0 = 01, or when MA1MA0 equals `addr_sel_i`. Any other address gets no acknowledge, and the data bytes that follow it change nothing.
- R2: After a matching address, and after every data byte written, the slave holds SDA low for the acknowledge clock.
- R3: In a divider pair, the first byte (bit 7 = 0) carries ratio bits 14..8 in its bits 6..0, and the second byte carries ratio bits 7..0. The pair sets `div_ratio_o`.
- R4: In a control pair, the first byte (bit 7 = 1) carries CP,T1,T0,TS2,TS1,TS0,OS in bits 6..0, and these go to `ctrl_o[6:0]` in that order. The second byte carries P7,P6,P5,P4,P3 in bits 7..3 and P0 in bit 0, and these go to `port_o` = {P7,P6,P5,P4,P3,P0}. Bits 2..1 of the second byte are ignored.
- R5: Any number of pairs may follow one address within a single transfer.
- R6: A register changes only after the second byte of its pair has been acknowledged. If a transfer ends after the first byte of a pair, or partway through any byte, the stored values stay as they were.
- R7: The read status byte, MSB first, is {POR, lock_i, port_in_i[2:0], adc_i[2:0]}. Here port_in_i is {P7,P5,P4}. The inputs are sampled when the byte is loaded.
- R8: When the master acknowledges a status byte, another status byte follows. When it does not, the slave releases SDA and sends nothing more until the next START.
- R9: The power-on flag is set by reset and by `pwr_low_i`. A STOP that ends a transfer in which a status byte was read clears it. While the flag is set, the divide ratio, control and ports read zero and writes have no effect.
- R10: The slave changes its SDA drive only while the filtered SCL is low, and it releases SDA on STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 2 | Variable address select code |
| pwr_low_i | input | 1 | Supply-low indication; sets the power-on flag |
| lock_i | input | 1 | Phase-lock indication |
| port_in_i | input | 3 | Port input levels {P7,P5,P4} |
| adc_i | input | 3 | Converter code |
| div_ratio_o | output | 15 | Programmed divide ratio |
| ctrl_o | output | 7 | {CP,T1,T0,TS2,TS1,TS0,OS} |
| port_o | output | 6 | {P7,P6,P5,P4,P3,P0}, 1 = on |

## Verification
Every bus edge reaches the decoder after about six clocks: two synchroniser stages, three filter samples and one state register. The acknowledge drive, the next status bit and a register commit are all due one clock after the filtered SCL edge that triggers them, so they land well inside a single quarter bit of twelve clocks. The bench master holds each bus level for a whole quarter bit. It samples acknowledges and read bits in the middle of the SCL high phase, and it reads the register outputs only after its task has finished the closing quarter of the acknowledge clock, when every commit has landed.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
    localparam int DIV_W  = 15;
    localparam int CTRL_W = 7;
    localparam int PORT_W = 6;
    localparam logic [4:0] DEV_HI    = 5'b11000;
    localparam logic [1:0] MA_ALWAYS = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
    } bus_st_e;
endpackage

// File: rtl/tuner_line_filter.sv
module tuner_line_filter #(
    parameter int LINES    = 2,
    parameter int FILT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    output logic [LINES-1:0] line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        typedef struct packed {
            logic [1:0]    sync;
            logic [CW-1:0] cnt;
            logic          lvl;
        } flt_t;
        flt_t flt_d, flt_q;

        always_comb begin
            flt_d      = flt_q;
            flt_d.sync = {flt_q.sync[0], line_i[g]};
            if (flt_q.sync[1] != flt_q.lvl) begin
                if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
                    flt_d.lvl = flt_q.sync[1];
                    flt_d.cnt = '0;
                end else begin
                    flt_d.cnt = flt_q.cnt + 1'b1;
                end
            end else begin
                flt_d.cnt = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flt_q <= '{sync: 2'b11, cnt: '0, lvl: 1'b1};
            else        flt_q <= flt_d;
        end

        assign line_o[g] = flt_q.lvl;
    end
endmodule

// File: rtl/tuner_regfile.sv
module tuner_regfile
    import tuner_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_div_i,
    input  logic              wr_ctrl_i,
    input  logic [6:0]        lead_i,
    input  logic [7:0]        tail_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [PORT_W-1:0] port_o
);
    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [CTRL_W-1:0] ctrl;
        logic [PORT_W-1:0] port;
    } rf_t;
    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (clr_i) begin
            rf_d = '0;
        end else if (wr_div_i) begin
            rf_d.div = {lead_i, tail_i};
        end else if (wr_ctrl_i) begin
            rf_d.ctrl = lead_i;
            rf_d.port = {tail_i[7:3], tail_i[0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign div_o  = rf_q.div;
    assign ctrl_o = rf_q.ctrl;
    assign port_o = rf_q.port;
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
    import tuner_i2c_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        addr_sel_i,
    input  logic              pwr_low_i,
    input  logic              lock_i,
    input  logic [2:0]        port_in_i,
    input  logic [2:0]        adc_i,
    output logic [DIV_W-1:0]  div_ratio_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [PORT_W-1:0] port_o
);
    typedef struct packed {
        bus_st_e    st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [6:0] pend;
        logic       kind;
        logic       phase;
        logic       rw;
        logic       ackm;
        logic       oe;
        logic       por;
        logic       rdflag;
        logic       scl_p;
        logic       sda_p;
    } ctl_t;
    ctl_t q, d;

    logic [1:0] lines_f;
    logic       scl_f, sda_f;
    logic       start_det, stop_det, scl_rise, scl_fall;
    logic       addr_hit, wr_div, wr_ctrl;
    logic [7:0] status;
    bus_st_e    st_cur;
    logic       por_cur;

    tuner_line_filter #(.LINES(2), .FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .line_i({scl_i, sda_i}), .line_o(lines_f)
    );
    assign scl_f = lines_f[1];
    assign sda_f = lines_f[0];

    assign start_det = scl_f && q.scl_p && q.sda_p && !sda_f;
    assign stop_det  = scl_f && q.scl_p && !q.sda_p && sda_f;
    assign scl_rise  = scl_f && !q.scl_p;
    assign scl_fall  = !scl_f && q.scl_p;
    assign addr_hit  = (q.sh[7:3] == DEV_HI) &&
                       ((q.sh[2:1] == MA_ALWAYS) || (q.sh[2:1] == addr_sel_i));
    assign status    = {q.por, lock_i, port_in_i, adc_i};

    always_comb begin
        d       = q;
        wr_div  = 1'b0;
        wr_ctrl = 1'b0;
        d.scl_p = scl_f;
        d.sda_p = sda_f;
        if (start_det) begin
            d.st = ST_ADDR; d.cnt = '0; d.oe = 1'b0; d.phase = 1'b0;
        end else if (stop_det) begin
            d.st = ST_IDLE; d.oe = 1'b0; d.phase = 1'b0; d.rdflag = 1'b0;
            if (q.rdflag) d.por = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_f};
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == ST_WDATA) begin
                            d.st = ST_WACK; d.oe = 1'b1;
                        end else if (addr_hit) begin
                            d.st = ST_AACK; d.oe = 1'b1; d.rw = q.sh[0];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: if (scl_fall) begin
                    d.cnt = '0;
                    if (q.rw) begin
                        d.st = ST_RDATA; d.sh = status; d.oe = !status[7]; d.rdflag = 1'b1;
                    end else begin
                        d.st = ST_WDATA; d.oe = 1'b0;
                    end
                end
                ST_WACK: if (scl_fall) begin
                    d.st = ST_WDATA; d.oe = 1'b0; d.cnt = '0;
                    if (!q.phase) begin
                        d.pend = q.sh[6:0]; d.kind = q.sh[7]; d.phase = 1'b1;
                    end else begin
                        d.phase = 1'b0;
                        wr_div  = !q.kind;
                        wr_ctrl = q.kind;
                    end
                end
                ST_RDATA: if (scl_fall) begin
                    if (q.cnt == 4'd7) begin
                        d.st = ST_RACK; d.oe = 1'b0;
                    end else begin
                        d.sh = {q.sh[6:0], 1'b0}; d.cnt = q.cnt + 1'b1; d.oe = !q.sh[6];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) d.ackm = !sda_f;
                    if (scl_fall) begin
                        if (q.ackm) begin
                            d.st = ST_RDATA; d.cnt = '0; d.sh = status; d.oe = !status[7];
                        end else begin
                            d.st = ST_IDLE; d.oe = 1'b0;
                        end
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
        if (pwr_low_i) d.por = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.por    <= 1'b1;
            q.scl_p  <= 1'b1;
            q.sda_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    tuner_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .clr_i(q.por),
        .wr_div_i(wr_div), .wr_ctrl_i(wr_ctrl),
        .lead_i(q.pend), .tail_i(q.sh),
        .div_o(div_ratio_o), .ctrl_o(ctrl_o), .port_o(port_o)
    );

    assign sda_oe_o = q.oe;
    assign st_cur   = q.st;
    assign por_cur  = q.por;
endmodule

// File: rtl/tuner_i2c_chk.sv
module tuner_i2c_chk
    import tuner_i2c_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_f,
    input logic              stop_det,
    input logic              sda_oe,
    input bus_st_e           st,
    input logic              por,
    input logic [DIV_W-1:0]  div,
    input logic [CTRL_W-1:0] ctrl,
    input logic [PORT_W-1:0] port
);
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe); // R8
    AST_POR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        por |=> (div == '0 && ctrl == '0 && port == '0)); // R9
    AST_DIV_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div) |-> ($past(st) == ST_WACK || $past(por))); // R6
    AST_PORT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port) |-> ($past(st) == ST_WACK || $past(por))); // R6
endmodule

bind tuner_i2c_slave tuner_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .stop_det(stop_det),
    .sda_oe(sda_oe_o), .st(st_cur), .por(por_cur),
    .div(div_ratio_o), .ctrl(ctrl_o), .port(port_o)
);

// File: tb/tuner_i2c_slave_tb.sv
`timescale 1ns/1ps
module tuner_i2c_slave_tb;
    localparam int Q = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_low = 1'b0;
    logic [1:0] addr_sel = 2'b00;
    logic pwr_low = 1'b0, lock = 1'b0;
    logic [2:0] pin = '0, adc = '0;
    logic sda_oe;
    logic [14:0] div;
    logic [6:0] ctrl;
    logic [5:0] port;
    wire sda_line = !(m_low || sda_oe);
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = !clk;

    tuner_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .addr_sel_i(addr_sel), .pwr_low_i(pwr_low), .lock_i(lock), .port_in_i(pin),
        .adc_i(adc), .div_ratio_o(div), .ctrl_o(ctrl), .port_o(port)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw(); repeat (Q) @(negedge clk); endtask

    task automatic bstart();
        m_low = 1'b0; qw(); m_scl = 1'b1; qw(); m_low = 1'b1; qw(); m_scl = 1'b0; qw();
    endtask

    task automatic bstop();
        m_low = 1'b1; qw(); m_scl = 1'b1; qw(); m_low = 1'b0; qw();
    endtask

    task automatic wbits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = !b[i]; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
        end
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        wbits(b, 8);
        m_low = 1'b0; qw(); m_scl = 1'b1; qw(); ack = !sda_line; qw(); m_scl = 1'b0; qw();
    endtask

    task automatic rbyte(input logic ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qw(); m_scl = 1'b1; qw(); b[i] = sda_line; qw(); m_scl = 1'b0; qw();
        end
        m_low = ack; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw(); m_low = 1'b0;
    endtask

    task automatic read_one(input string tag, input logic [7:0] exp);
        logic a; logic [7:0] b;
        bstart(); wbyte(8'hC3, a); chk({tag, " R2 read ack"}, a, 1);
        rbyte(1'b0, b); chk({tag, " R7 status"}, b, exp);
        bstop(); chk({tag, " R8 released"}, sda_oe, 0);
    endtask

    initial begin
        logic a; logic [7:0] b; logic [14:0] v; logic [6:0] cv; logic [7:0] dv;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 reset div", div, 0); chk("R9 reset ctrl", ctrl, 0);
        chk("R9 reset port", port, 0); chk("R10 reset sda", sda_oe, 0);

        lock = 1'b1; pin = 3'b101; adc = 3'b011;
        bstart(); wbyte(8'hC2, a); chk("R1 fixed addr ack", a, 1);
        wbyte(8'h12, a); chk("R2 data ack", a, 1);
        wbyte(8'h34, a); chk("R2 data ack", a, 1);
        bstop(); chk("R9 write ignored while flag set", div, 0);
        read_one("por set", 8'hEB);
        read_one("por clear", 8'h6B);

        for (int k = 0; k < 8; k++) begin
            lock = k[0]; pin = 3'(k); adc = 3'(7 - k);
            read_one("R7 sweep", {1'b0, lock, pin, adc});
        end

        lock = 1'b1; pin = 3'b110; adc = 3'b001;
        bstart(); wbyte(8'hC3, a);
        rbyte(1'b1, b); chk("R8 first byte", b, 8'h71);
        rbyte(1'b1, b); chk("R8 repeat byte", b, 8'h71);
        rbyte(1'b0, b); chk("R8 third byte", b, 8'h71);
        repeat (Q) @(negedge clk); chk("R8 nack release", sda_oe, 0);
        bstop();

        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                addr_sel = 2'(s);
                bstart(); wbyte({5'b11000, 2'(m), 1'b0}, a);
                chk($sformatf("R1 addr ma=%0d sel=%0d", m, s), a, int'(m == 1 || m == s));
                bstop(); chk("R10 stop release", sda_oe, 0);
            end
        end
        addr_sel = 2'b00;

        bstart(); wbyte(8'hC2, a);
        for (int i = 0; i < 17; i++) begin
            v = (i < 15) ? 15'(1 << i) : ((i == 15) ? 15'h7FFF : 15'h2AD5);
            wbyte({1'b0, v[14:8]}, a); wbyte(v[7:0], a); chk("R2 pair ack", a, 1);
            chk("R3 R5 divide ratio", div, v);
        end
        bstop();

        bstart(); wbyte(8'hC2, a);
        for (int i = 0; i < 8; i++) begin
            cv = 7'(i * 37 + 5); dv = 8'(i * 53 + 9);
            wbyte({1'b1, cv}, a); wbyte(dv, a);
            chk("R4 control", ctrl, cv);
            chk("R4 ports", port, {dv[7:3], dv[0]});
        end
        bstop();
        chk("R4 divider kept", div, 15'h2AD5);

        bstart(); wbyte(8'hC2, a); wbyte(8'h05, a); bstop();
        chk("R6 lone first byte", div, 15'h2AD5);
        bstart(); wbyte(8'hC2, a); wbyte(8'h05, a); wbits(8'h66, 4); bstop();
        chk("R6 cut byte", div, 15'h2AD5);
        bstart(); wbyte(8'hC2, a); wbyte(8'h05, a);
        chk("R6 mid pair", div, 15'h2AD5);
        wbyte(8'h66, a); chk("R6 pair done", div, 15'h0566);
        bstop();

        addr_sel = 2'b00;
        bstart(); wbyte(8'hC6, a); chk("R1 other addr nack", a, 0);
        wbyte(8'h01, a); wbyte(8'h02, a); bstop();
        chk("R1 foreign data ignored", div, 15'h0566);

        pwr_low = 1'b1; repeat (4) @(negedge clk); pwr_low = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 supply low div", div, 0); chk("R9 supply low port", port, 0);
        lock = 1'b0; pin = 3'b000; adc = 3'b000;
        read_one("R9 flag back", 8'h80);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule